// File: doc/BRIEF.md
# Internal Data RAM and SFR Access Unit

This unit serves the data-memory accesses of an 8032-class core. It holds 256 bytes of on-chip RAM and, for each byte access, picks the target from the address and the addressing mode. Direct accesses below 0x80 reach RAM. Direct accesses at 0x80 and above leave the unit on a special-function-register port. Indirect accesses reach the whole 256-byte RAM. Register-bank accesses reach one of four 8-byte banks at the bottom of RAM.

A separate bit channel works on single bits. Bit addresses below 0x80 fall in a 16-byte bit area of RAM that starts at 0x20. Bit addresses at 0x80 and above select one of the 16 SFRs whose address is a multiple of 8. A bit write is a read-modify-write of the target byte that completes in one cycle. Read data for both channels is registered. The peripherals answer SFR accesses combinationally, with data and a hit flag.

Top module: `iram_sfr_unit`

## Requirements
- R1: A direct access (mode_i = 0) with addr_i < 0x80 reads or writes RAM byte addr_i, which is the same byte an indirect access to that address reaches.
- R2: A register-bank access (mode_i = 2) reaches RAM byte {3'b000, bank_sel_i, addr_i[2:0]}. Only addr_i[2:0] is used.
- R3: An indirect access (mode_i = 1) reaches RAM byte addr_i over the full range 0x00-0xFF. Push and pop sequences therefore run across 0x7F/0x80 with no seam.
- R4: A direct access with addr_i >= 0x80 goes to the SFR port: sfr_addr_o = addr_i, with sfr_re_o on a read or sfr_we_o on a write. The RAM byte at that address is not changed. Indirect accesses never assert sfr_re_o or sfr_we_o.
- R5: An SFR read for which sfr_hit_i is low returns 0x00, whatever sfr_rdata_i carries.
- R6: A bit address b < 0x80 selects bit b[2:0] of RAM byte 0x20 + b[6:3].
- R7: A bit address b >= 0x80 selects bit b[2:0] of the SFR at {b[7:3], 3'b000}. The SFR port carries this address with sfr_re_o asserted.
- R8: A bit write replaces only the selected bit of the target byte and keeps the other seven. Read and write-back happen in the same cycle, so for an SFR target sfr_re_o and sfr_we_o are both high.
- R9: When acc_en_i and bit_en_i are high in the same cycle, the byte access is carried out and the bit operation is dropped: no write, and bit_rdata_o does not change.
- R10: Read data appears on rdata_o or bit_rdata_o one clock after the request. The output holds its value through every cycle that is not a read on its channel.
- R11: mode_i = 3 is reserved. It writes nothing, raises no SFR strobe and leaves rdata_o unchanged.
- R12: While rst_ni is low, rdata_o and bit_rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Byte access request |
| mode_i | input | 2 | 0 direct, 1 indirect, 2 register bank, 3 reserved |
| addr_i | input | 8 | Byte address, or register number in bank mode |
| bank_sel_i | input | 2 | Active register bank |
| we_i | input | 1 | Byte write enable |
| wdata_i | input | 8 | Byte write data |
| rdata_o | output | 8 | Registered byte read data |
| bit_en_i | input | 1 | Bit operation request |
| bit_we_i | input | 1 | Bit write enable |
| bit_addr_i | input | 8 | Bit address |
| bit_wdata_i | input | 1 | Bit write value |
| bit_rdata_o | output | 1 | Registered bit read value |
| sfr_addr_o | output | 8 | SFR address |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_rdata_i | input | 8 | SFR read data from peripherals |
| sfr_hit_i | input | 1 | Peripheral claims sfr_addr_o |

## Verification
Several rules hold in every cycle and are checked by assertions. Indirect and reserved-mode accesses raise no SFR strobe. Direct upper addresses and SFR bit addresses show the right address and strobes on the port. A bit write to an SFR changes only the selected bit. Misses read as zero, and the read outputs hold through non-read cycles. Other behaviour can only be seen by the bench's sequences: RAM contents across modes, bank address forming, the two RAM spaces at 0x80-0xFF staying apart, stack traffic across 0x7F/0x80, and dropped bit operations leaving memory unchanged.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [1:0] {
    MODE_DIR  = 2'd0,
    MODE_IND  = 2'd1,
    MODE_BANK = 2'd2,
    MODE_RSVD = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/iram_route.sv
module iram_route import iram_pkg::*; #(
  parameter int AW       = 8,
  parameter int IW       = 3,
  parameter int BW       = 2,
  parameter int RW       = 3,
  parameter int BIT_BASE = 32
) (
  input  logic          acc_en_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bank_sel_i,
  input  logic          bit_en_i,
  input  logic [AW-1:0] bit_addr_i,
  output logic          byte_ram_o,
  output logic          byte_sfr_o,
  output logic [AW-1:0] byte_ram_addr_o,
  output logic          bit_ram_o,
  output logic          bit_sfr_o,
  output logic [AW-1:0] bit_ram_addr_o,
  output logic [AW-1:0] bit_sfr_addr_o,
  output logic [IW-1:0] bit_idx_o
);
  logic upper;
  assign upper = addr_i[AW-1];

  always_comb begin
    byte_ram_o      = 1'b0;
    byte_sfr_o      = 1'b0;
    byte_ram_addr_o = addr_i;
    if (acc_en_i) begin
      unique case (mode_i)
        MODE_DIR: begin
          byte_ram_o = !upper;
          byte_sfr_o = upper;
        end
        MODE_IND:  byte_ram_o = 1'b1;
        MODE_BANK: begin
          byte_ram_o      = 1'b1;
          byte_ram_addr_o = AW'({bank_sel_i, addr_i[RW-1:0]});
        end
        default: ;
      endcase
    end
  end

  // byte access wins over a concurrent bit operation
  logic bit_act;
  assign bit_act        = bit_en_i && !acc_en_i;
  assign bit_ram_o      = bit_act && !bit_addr_i[AW-1];
  assign bit_sfr_o      = bit_act && bit_addr_i[AW-1];
  assign bit_ram_addr_o = AW'(BIT_BASE) + AW'(bit_addr_i[AW-2:IW]);
  assign bit_sfr_addr_o = {bit_addr_i[AW-1:IW], {IW{1'b0}}};
  assign bit_idx_o      = bit_addr_i[IW-1:0];
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] byte_i,
  input  logic [IW-1:0] idx_i,
  input  logic          bit_i,
  output logic [DW-1:0] byte_o,
  output logic          bit_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign byte_o[i] = (32'(idx_i) == i) ? bit_i : byte_i[i];
  end
  assign bit_o = byte_i[idx_i];
endmodule

// File: rtl/iram_sfr_unit.sv
module iram_sfr_unit import iram_pkg::*; #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BANKS    = 4,
  parameter int BANK_REG = 8,
  parameter int BIT_BASE = 32,
  localparam int BW = $clog2(BANKS),
  localparam int RW = $clog2(BANK_REG),
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_en_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bank_sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          bit_en_i,
  input  logic          bit_we_i,
  input  logic [AW-1:0] bit_addr_i,
  input  logic          bit_wdata_i,
  output logic          bit_rdata_o,
  output logic [AW-1:0] sfr_addr_o,
  output logic [DW-1:0] sfr_wdata_o,
  output logic          sfr_we_o,
  output logic          sfr_re_o,
  input  logic [DW-1:0] sfr_rdata_i,
  input  logic          sfr_hit_i
);
  logic          byte_ram, byte_sfr, bit_ram, bit_sfr;
  logic [AW-1:0] byte_ram_addr, bit_ram_addr, bit_sfr_addr;
  logic [IW-1:0] bit_idx;

  iram_route #(
    .AW(AW), .IW(IW), .BW(BW), .RW(RW), .BIT_BASE(BIT_BASE)
  ) u_route (
    .acc_en_i       (acc_en_i),
    .mode_i         (mode_i),
    .addr_i         (addr_i),
    .bank_sel_i     (bank_sel_i),
    .bit_en_i       (bit_en_i),
    .bit_addr_i     (bit_addr_i),
    .byte_ram_o     (byte_ram),
    .byte_sfr_o     (byte_sfr),
    .byte_ram_addr_o(byte_ram_addr),
    .bit_ram_o      (bit_ram),
    .bit_sfr_o      (bit_sfr),
    .bit_ram_addr_o (bit_ram_addr),
    .bit_sfr_addr_o (bit_sfr_addr),
    .bit_idx_o      (bit_idx)
  );

  logic [DW-1:0] sfr_q, ram_q, bit_src, bit_merged;
  logic [AW-1:0] ram_addr;
  logic          ram_we, bit_sel;

  assign sfr_q    = sfr_hit_i ? sfr_rdata_i : '0;
  assign ram_addr = byte_ram ? byte_ram_addr : bit_ram_addr;
  assign ram_we   = (byte_ram && we_i) || (bit_ram && bit_we_i);
  assign bit_src  = bit_ram ? ram_q : sfr_q;

  iram_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_addr),
    .wdata_i(byte_ram ? wdata_i : bit_merged),
    .raddr_i(ram_addr),
    .rdata_o(ram_q)
  );

  iram_bit_merge #(.DW(DW)) u_merge (
    .byte_i(bit_src),
    .idx_i (bit_idx),
    .bit_i (bit_wdata_i),
    .byte_o(bit_merged),
    .bit_o (bit_sel)
  );

  // SFR port: byte path and bit path are mutually exclusive
  assign sfr_re_o    = (byte_sfr && !we_i) || bit_sfr;
  assign sfr_we_o    = (byte_sfr && we_i) || (bit_sfr && bit_we_i);
  assign sfr_addr_o  = byte_sfr ? addr_i  : (bit_sfr ? bit_sfr_addr : '0);
  assign sfr_wdata_o = byte_sfr ? wdata_i : (bit_sfr ? bit_merged : '0);

  logic byte_rd, bit_rd;
  assign byte_rd = acc_en_i && !we_i && (mode_i != MODE_RSVD);
  assign bit_rd  = (bit_ram || bit_sfr) && !bit_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      bit_rdata_o <= 1'b0;
    end else begin
      if (byte_rd) rdata_o     <= byte_ram ? ram_q : sfr_q;
      if (bit_rd)  bit_rdata_o <= bit_sel;
    end
  end
endmodule

// File: rtl/iram_sfr_chk.sv
module iram_sfr_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_en_i,
  input logic [1:0]    mode_i,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic [DW-1:0] rdata_o,
  input logic          bit_en_i,
  input logic          bit_we_i,
  input logic [AW-1:0] bit_addr_i,
  input logic          bit_rdata_o,
  input logic [AW-1:0] sfr_addr_o,
  input logic [DW-1:0] sfr_wdata_o,
  input logic          sfr_we_o,
  input logic          sfr_re_o,
  input logic [DW-1:0] sfr_rdata_i,
  input logic          sfr_hit_i
);
  logic [DW-1:0] keep_mask;
  assign keep_mask = ~(DW'(1) << bit_addr_i[$clog2(DW)-1:0]);

  p_indirect_no_sfr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 2'd1 |-> !sfr_re_o && !sfr_we_o);

  p_direct_upper_sfr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 2'd0 && addr_i[AW-1]
    |-> sfr_addr_o == addr_i && (we_i ? (sfr_we_o && !sfr_re_o) : (sfr_re_o && !sfr_we_o)));

  p_miss_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && !we_i && mode_i == 2'd0 && addr_i[AW-1] && !sfr_hit_i |=> rdata_o == '0);

  p_bit_sfr_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !acc_en_i && bit_addr_i[AW-1]
    |-> sfr_re_o && sfr_addr_o[AW-1:3] == bit_addr_i[AW-1:3] && sfr_addr_o[2:0] == 3'b000);

  p_bit_rmw_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && bit_we_i && !acc_en_i && bit_addr_i[AW-1] && sfr_hit_i
    |-> sfr_we_o && sfr_re_o && ((sfr_wdata_o & keep_mask) == (sfr_rdata_i & keep_mask)));

  p_bit_dropped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && bit_en_i |=> $stable(bit_rdata_o));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_en_i && !we_i && mode_i != 2'd3) |=> $stable(rdata_o));

  p_reserved_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i && mode_i == 2'd3 |-> !sfr_re_o && !sfr_we_o);
endmodule

bind iram_sfr_unit iram_sfr_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_en_i   (acc_en_i),
  .mode_i     (mode_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .bit_en_i   (bit_en_i),
  .bit_we_i   (bit_we_i),
  .bit_addr_i (bit_addr_i),
  .bit_rdata_o(bit_rdata_o),
  .sfr_addr_o (sfr_addr_o),
  .sfr_wdata_o(sfr_wdata_o),
  .sfr_we_o   (sfr_we_o),
  .sfr_re_o   (sfr_re_o),
  .sfr_rdata_i(sfr_rdata_i),
  .sfr_hit_i  (sfr_hit_i)
);

// File: tb/iram_sfr_unit_tb_top.sv
module iram_sfr_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_en_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] addr_i = '0;
  logic [1:0] bank_sel_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       bit_en_i = 1'b0;
  logic       bit_we_i = 1'b0;
  logic [7:0] bit_addr_i = '0;
  logic       bit_wdata_i = 1'b0;
  logic       bit_rdata_o;
  logic [7:0] sfr_addr_o, sfr_wdata_o;
  logic       sfr_we_o, sfr_re_o;
  logic [7:0] sfr_rdata_i;
  logic       sfr_hit_i;

  always #10 clk_i = ~clk_i;

  iram_sfr_unit dut_i (.*);

  // peripheral model: 0x80-0x9F and 0xA8 are implemented
  logic [7:0] sfr_mem [256];
  function automatic bit impl(input logic [7:0] a);
    return (a >= 8'h80 && a < 8'hA0) || a == 8'hA8;
  endfunction
  assign sfr_hit_i   = impl(sfr_addr_o);
  assign sfr_rdata_i = impl(sfr_addr_o) ? sfr_mem[sfr_addr_o] : 8'hA5;
  always @(posedge clk_i) if (sfr_we_o && impl(sfr_addr_o)) sfr_mem[sfr_addr_o] <= sfr_wdata_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [8:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: outputs registered at posedge, compared at the following negedge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e[8]) chk(bit_rdata_o == e[0], t, {7'b0, bit_rdata_o}, {7'b0, e[0]});
      else      chk(rdata_o == e[7:0], t, rdata_o, e[7:0]);
    end
  end

  task automatic idle();
    acc_en_i = 1'b0; we_i = 1'b0; bit_en_i = 1'b0; bit_we_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = m; addr_i = a; we_i = 1'b1; wdata_i = d;
    @(posedge clk_i); #2; idle();
  endtask

  task automatic rd(input logic [1:0] m, input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = m; addr_i = a; we_i = 1'b0;
    @(posedge clk_i); #2; idle();
    exp_q.push_back({1'b0, exp}); tag_q.push_back(tag);
  endtask

  task automatic bwr(input logic [7:0] ba, input logic v);
    @(negedge clk_i);
    bit_en_i = 1'b1; bit_we_i = 1'b1; bit_addr_i = ba; bit_wdata_i = v;
    @(posedge clk_i); #2; idle();
  endtask

  task automatic brd(input logic [7:0] ba, input logic exp, input string tag);
    @(negedge clk_i);
    bit_en_i = 1'b1; bit_we_i = 1'b0; bit_addr_i = ba;
    @(posedge clk_i); #2; idle();
    exp_q.push_back({1'b1, 7'b0, exp}); tag_q.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) sfr_mem[i] = 8'h00;
    repeat (3) @(posedge clk_i);
    #2;
    chk(rdata_o == 8'h00, "R12 reset rdata", rdata_o, 8'h00);
    chk(bit_rdata_o == 1'b0, "R12 reset bit_rdata", {7'b0, bit_rdata_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 direct lower RAM shared with indirect
    wr(2'd0, 8'h45, 8'h3C);
    rd(2'd1, 8'h45, 8'h3C, "R1 indirect sees direct write");
    rd(2'd0, 8'h45, 8'h3C, "R1 direct read");

    // R2 register banks
    bank_sel_i = 2'd2;
    wr(2'd2, 8'hF5, 8'h77);
    bank_sel_i = 2'd0;
    wr(2'd2, 8'h05, 8'h11);
    rd(2'd1, 8'h15, 8'h77, "R2 bank2 r5 at 0x15");
    rd(2'd1, 8'h05, 8'h11, "R2 bank0 r5 at 0x05");
    bank_sel_i = 2'd2;
    rd(2'd2, 8'h05, 8'h77, "R2 bank read");

    // R3 indirect upper RAM and stack across the seam
    wr(2'd1, 8'hC3, 8'hE1);
    rd(2'd1, 8'hC3, 8'hE1, "R3 indirect upper");
    for (int i = 0; i < 4; i++) wr(2'd1, 8'h7E + 8'(i), 8'hA0 + 8'(i));
    for (int i = 3; i >= 0; i--) rd(2'd1, 8'h7E + 8'(i), 8'hA0 + 8'(i), "R3 stack pop");

    // R4 direct upper goes to SFRs, RAM untouched
    wr(2'd1, 8'h90, 8'h13);
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd0; addr_i = 8'h90; we_i = 1'b1; wdata_i = 8'h42;
    #1;
    chk(sfr_we_o && !sfr_re_o && sfr_addr_o == 8'h90, "R4 direct write strobe", sfr_addr_o, 8'h90);
    @(posedge clk_i); #2; idle();
    chk(sfr_mem[8'h90] == 8'h42, "R4 SFR written", sfr_mem[8'h90], 8'h42);
    rd(2'd1, 8'h90, 8'h13, "R4 RAM 0x90 untouched");
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd1; addr_i = 8'h85; we_i = 1'b0;
    #1;
    chk(!sfr_re_o && !sfr_we_o, "R4 indirect no strobe", {6'b0, sfr_re_o, sfr_we_o}, 8'h00);
    @(posedge clk_i); #2; idle();

    // R5 miss reads zero
    rd(2'd0, 8'hC3, 8'h00, "R5 unimplemented SFR read");

    // R6 and R8 RAM bit area
    wr(2'd1, 8'h25, 8'hF0);
    bwr(8'h2B, 1'b1);
    bwr(8'h2C, 1'b0);
    rd(2'd1, 8'h25, 8'hE8, "R8 only selected bits changed");
    brd(8'h2D, 1'b1, "R6 bit 0x2D");
    brd(8'h2C, 1'b0, "R6 bit 0x2C");

    // R7 and R8 SFR bits
    @(negedge clk_i);
    bit_en_i = 1'b1; bit_we_i = 1'b1; bit_addr_i = 8'h93; bit_wdata_i = 1'b1;
    #1;
    chk(sfr_re_o && sfr_we_o && sfr_addr_o == 8'h90, "R8 SFR rmw strobes", sfr_addr_o, 8'h90);
    @(posedge clk_i); #2; idle();
    rd(2'd0, 8'h90, 8'h4A, "R7 SFR bit set");
    brd(8'h96, 1'b1, "R7 SFR bit read");
    bwr(8'h81, 1'b1);
    rd(2'd0, 8'h80, 8'h02, "R7 SFR 0x80 bit1");

    // R9 byte access beats bit op
    brd(8'h2C, 1'b0, "R9 setup bit");
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd0; addr_i = 8'h30; we_i = 1'b1; wdata_i = 8'h99;
    bit_en_i = 1'b1; bit_we_i = 1'b1; bit_addr_i = 8'h28; bit_wdata_i = 1'b1;
    @(posedge clk_i); #2; idle();
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd1; addr_i = 8'h25; we_i = 1'b0;
    bit_en_i = 1'b1; bit_we_i = 1'b0; bit_addr_i = 8'h2D;
    @(posedge clk_i); #2; idle();
    exp_q.push_back({1'b0, 8'hE8}); tag_q.push_back("R9 byte 0x25 unchanged");
    exp_q.push_back({1'b1, 8'h00}); tag_q.push_back("R9 bit read dropped");
    @(negedge clk_i);
    rd(2'd0, 8'h30, 8'h99, "R9 byte write done");

    // R10 hold through a write
    wr(2'd0, 8'h31, 8'h55);
    @(negedge clk_i);
    chk(rdata_o == 8'h99, "R10 hold after write", rdata_o, 8'h99);

    // R11 reserved mode
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd3; addr_i = 8'h45; we_i = 1'b1; wdata_i = 8'hFF;
    #1;
    chk(!sfr_re_o && !sfr_we_o, "R11 reserved no strobe", {6'b0, sfr_re_o, sfr_we_o}, 8'h00);
    @(posedge clk_i); #2; idle();
    @(negedge clk_i);
    acc_en_i = 1'b1; mode_i = 2'd3; addr_i = 8'h45; we_i = 1'b0;
    @(posedge clk_i); #2; idle();
    @(negedge clk_i);
    chk(rdata_o == 8'h99, "R11 reserved read no update", rdata_o, 8'h99);
    rd(2'd1, 8'h45, 8'h3C, "R11 reserved write ignored");

    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule